// File: doc/BRIEF.md
# Power-Gated Sound Control Register Bank

This block stores the control bytes of a four-channel sound unit. It also stores a master byte whose top bit switches the whole unit on or off. A CPU reaches the block over a plain byte bus with an address, write data, a write strobe and a read strobe. Read data is registered and appears one cycle after the read strobe. The block does not generate sound. It hands the stored control bytes, a power flag and a length-load strobe to the channel logic next to it.

Clearing the power bit wipes every channel and mixer byte. While power stays off, control writes are refused. A legacy-mode input keeps a small set of length writes working while power is off. On read, each register's unused and write-only bits come back as ones, through a fixed OR pattern for that register. The master byte reads back the live per-channel activity flags that the sound unit reports.

Register index map (index equals bus address):

| Index | Register | Read OR pattern |
|---|---|---|
| 0 | tone 1 sweep | 0x80 |
| 1 | tone 1 duty and length | 0x3F |
| 2 | tone 1 envelope | 0x00 |
| 3 | tone 1 period low | 0xFF |
| 4 | tone 1 period high and trigger | 0xBF |
| 5 | tone 2 duty and length | 0x3F |
| 6 | tone 2 envelope | 0x00 |
| 7 | tone 2 period low | 0xFF |
| 8 | tone 2 period high and trigger | 0xBF |
| 9 | wave enable | 0x7F |
| 10 | wave length | 0xFF |
| 11 | wave level | 0x9F |
| 12 | wave period low | 0xFF |
| 13 | wave period high and trigger | 0xBF |
| 14 | noise length | 0xFF |
| 15 | noise envelope | 0x00 |
| 16 | noise polynomial | 0x00 |
| 17 | noise control and trigger | 0xBF |
| 18 | mixer volume | 0x00 |
| 19 | mixer panning | 0x00 |
| 20 | master | 0x70 |

Indices 0 to 19 are the control registers. Addresses 21 and above are unmapped.

Top module: `snd_reg_bank`

## Requirements
- R1: While `powerOn` is 0, a write to control indices 0 to 19 leaves the stored byte at 0. The exceptions are those in R3.
- R2: Writing the master register (index 20) with bit 7 = 0 sets all twenty bytes of `ctrlRegs` to 0 at that same clock edge. `powerOn` falls at that edge too.
- R3: While `powerOn` is 0 and `legacyMode` is 1, writes to index 10 and index 14 are stored in full. While `powerOn` is 0 and `legacyMode` is 0, writes to those indices are discarded.
- R4: An accepted write to index 1, 5, 10 or 14 pulses `lenLoad` bit 0, 1, 2 or 3 for one cycle after the write edge. On index 1 or 5, `lenValue` carries the write data ANDed with 0x3F. On index 10 or 14 it carries the full byte. While power is off, a write to index 1 or 5 still pulses in legacy mode but stores 0. In non-legacy mode no pulse occurs while power is off.
- R5: Reading a mapped control index returns the stored byte ORed with that register's read OR pattern from the map above.
- R6: A master write takes only bit 7 from the data. Reading the master register returns {power bit, 3'b111, `chanActive`}, with `chanActive` sampled at the read edge.
- R7: After reset, `powerOn` = 1 and the mixer volume holds 0x77. The mixer panning holds 0xF3. Every other control byte holds 0, and `busRdata` = 0x00.
- R8: Addresses 21 and above read 0xFF, and writes to them change nothing.
- R9: `busRdata` is loaded only at an edge where `busRd` = 1. It holds its value otherwise.
- R10: While `powerOn` is 1, a write stores the full data byte at its index. The write appears in `ctrlRegs[8*i +: 8]` after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe |
| busAddr | input | ADDR_W (5) | Register index |
| busWdata | input | 8 | Write data |
| legacyMode | input | 1 | 1 selects the legacy write rules for power-off |
| chanActive | input | 4 | Live per-channel activity flags from the sound unit |
| busRdata | output | 8 | Registered read data |
| powerOn | output | 1 | Stored master power bit |
| ctrlRegs | output | 160 | Stored control bytes, index i at bits 8*i+7 to 8*i |
| lenLoad | output | 4 | One-cycle length-load strobe, one bit per channel |
| lenValue | output | 8 | Length value that goes with `lenLoad` |

## Verification
The embedded properties check four things on every cycle:
- While power is off, the non-length bytes stay at zero.
- Every byte is zero right after power falls.
- In non-legacy mode no length strobe follows a power-off write.
- Read data holds between read strobes, always carries each register's OR pattern, and reports the live channel flags on master reads.

Only the bench scenarios can show the rest:
- The exact stored values and the per-register read results.
- The legacy-mode exceptions for the length registers.
- The masked strobe value for the duty registers.
- That unmapped addresses leave the register image untouched.

// File: rtl/snd_reg_pkg.sv
package snd_reg_pkg;

  localparam int DATA_W   = 8;
  localparam int NUM_CTRL = 20;
  localparam int NUM_REGS = NUM_CTRL + 1;
  localparam int IDX_W    = $clog2(NUM_REGS);
  localparam int NUM_CHAN = 4;

  localparam int IDX_T1_DUTY = 1;
  localparam int IDX_T2_DUTY = 5;
  localparam int IDX_WV_LEN  = 10;
  localparam int IDX_NZ_LEN  = 14;
  localparam int IDX_VOL     = 18;
  localparam int IDX_PAN     = 19;
  localparam int IDX_MASTER  = 20;

  typedef struct packed {
    logic                ctrlWe;
    logic [IDX_W-1:0]    idx;
    logic                clearAll;
    logic                pwrWe;
    logic                pwrVal;
    logic [NUM_CHAN-1:0] lenWe;
    logic [DATA_W-1:0]   lenData;
  } strobe_t;

  // Bits forced to one on read-back.
  function automatic logic [DATA_W-1:0] readMask(int idx);
    case (idx)
      0:                      return 8'h80;
      1, 5:                   return 8'h3F;
      2, 6, 15, 16, 18, 19:   return 8'h00;
      3, 7, 10, 12, 14:       return 8'hFF;
      4, 8, 13, 17:           return 8'hBF;
      9:                      return 8'h7F;
      11:                     return 8'h9F;
      IDX_MASTER:             return 8'h70;
      default:                return 8'hFF;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] resetVal(int idx);
    case (idx)
      IDX_VOL: return 8'h77;
      IDX_PAN: return 8'hF3;
      default: return 8'h00;
    endcase
  endfunction

  // Ones on every byte that must stay zero while power is off.
  function automatic logic [NUM_CTRL*DATA_W-1:0] offZeroMask();
    logic [NUM_CTRL*DATA_W-1:0] m;
    for (int i = 0; i < NUM_CTRL; i++) begin
      m[i*DATA_W +: DATA_W] = (i == IDX_WV_LEN || i == IDX_NZ_LEN) ? 8'h00 : 8'hFF;
    end
    return m;
  endfunction

endpackage

// File: rtl/snd_reg_ctl.sv
module snd_reg_ctl
  import snd_reg_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              legacyMode,
  input  logic              powerOn,
  output strobe_t           strobe
);

  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NUM_REGS - 1);

  logic mapped;
  logic isMaster;
  logic isDuty;
  logic isLenOnly;
  logic lenGate;

  always_comb begin
    mapped    = (busAddr <= LAST_ADDR);
    isMaster  = (busAddr == ADDR_W'(IDX_MASTER));
    isDuty    = (busAddr == ADDR_W'(IDX_T1_DUTY)) || (busAddr == ADDR_W'(IDX_T2_DUTY));
    isLenOnly = (busAddr == ADDR_W'(IDX_WV_LEN)) || (busAddr == ADDR_W'(IDX_NZ_LEN));
    // Length strobes survive power-off only under the legacy rules.
    lenGate   = busWr && (powerOn || legacyMode);

    strobe.idx      = busAddr[IDX_W-1:0];
    strobe.ctrlWe   = busWr && mapped && !isMaster &&
                      (powerOn || (legacyMode && isLenOnly));
    strobe.pwrWe    = busWr && isMaster;
    strobe.pwrVal   = busWdata[DATA_W-1];
    strobe.clearAll = busWr && isMaster && !busWdata[DATA_W-1];

    strobe.lenWe = '0;
    if (lenGate) begin
      case (busAddr)
        ADDR_W'(IDX_T1_DUTY): strobe.lenWe = 4'b0001;
        ADDR_W'(IDX_T2_DUTY): strobe.lenWe = 4'b0010;
        ADDR_W'(IDX_WV_LEN):  strobe.lenWe = 4'b0100;
        ADDR_W'(IDX_NZ_LEN):  strobe.lenWe = 4'b1000;
        default:              strobe.lenWe = '0;
      endcase
    end
    strobe.lenData = isDuty ? (busWdata & 8'h3F) : busWdata;
  end

endmodule

// File: rtl/snd_reg_dp.sv
module snd_reg_dp
  import snd_reg_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic                       clk,
  input  logic                       rst,
  input  strobe_t                    strobe,
  input  logic [DATA_W-1:0]          busWdata,
  input  logic                       busRd,
  input  logic [ADDR_W-1:0]          busAddr,
  input  logic [NUM_CHAN-1:0]        chanActive,
  output logic [DATA_W-1:0]          busRdata,
  output logic                       powerOn,
  output logic [NUM_CTRL*DATA_W-1:0] ctrlRegs,
  output logic [NUM_CHAN-1:0]        lenLoad,
  output logic [DATA_W-1:0]          lenValue
);

  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NUM_REGS - 1);

  logic [DATA_W-1:0] store [NUM_CTRL];
  logic [DATA_W-1:0] rdNext;
  logic [IDX_W-1:0]  rdIdx;
  logic              rdMapped;

  for (genvar i = 0; i < NUM_CTRL; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        store[i] <= resetVal(i);
      end else if (strobe.clearAll) begin
        store[i] <= '0;
      end else if (strobe.ctrlWe && (strobe.idx == IDX_W'(i))) begin
        store[i] <= busWdata;
      end
    end
    assign ctrlRegs[i*DATA_W +: DATA_W] = store[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      powerOn <= 1'b1;
    end else if (strobe.pwrWe) begin
      powerOn <= strobe.pwrVal;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lenLoad  <= '0;
      lenValue <= '0;
    end else begin
      lenLoad  <= strobe.lenWe;
      lenValue <= strobe.lenData;
    end
  end

  always_comb begin
    rdIdx    = busAddr[IDX_W-1:0];
    rdMapped = (busAddr <= LAST_ADDR);
    if (!rdMapped) begin
      rdNext = 8'hFF;
    end else if (rdIdx == IDX_W'(IDX_MASTER)) begin
      rdNext = {powerOn, 3'b111, chanActive};
    end else begin
      rdNext = store[rdIdx] | readMask(int'(rdIdx));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busRdata <= '0;
    end else if (busRd) begin
      busRdata <= rdNext;
    end
  end

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !busRd |=> $stable(busRdata)) else $error("read data moved without strobe"); // R9

  AST_RD_MASK: assert property (@(posedge clk) disable iff (rst)
    (busRd && rdMapped) |=>
      ((busRdata & readMask(int'($past(rdIdx)))) == readMask(int'($past(rdIdx)))))
    else $error("read pattern bits missing"); // R5

  AST_RD_MASTER: assert property (@(posedge clk) disable iff (rst)
    (busRd && rdMapped && rdIdx == IDX_W'(IDX_MASTER)) |=>
      (busRdata[6:0] == {3'b111, $past(chanActive)}))
    else $error("master read wrong"); // R6

endmodule

// File: rtl/snd_reg_bank.sv
module snd_reg_bank
  import snd_reg_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       busWr,
  input  logic                       busRd,
  input  logic [ADDR_W-1:0]          busAddr,
  input  logic [DATA_W-1:0]          busWdata,
  input  logic                       legacyMode,
  input  logic [NUM_CHAN-1:0]        chanActive,
  output logic [DATA_W-1:0]          busRdata,
  output logic                       powerOn,
  output logic [NUM_CTRL*DATA_W-1:0] ctrlRegs,
  output logic [NUM_CHAN-1:0]        lenLoad,
  output logic [DATA_W-1:0]          lenValue
);

  localparam logic [NUM_CTRL*DATA_W-1:0] OFF_ZERO = offZeroMask();

  strobe_t strobe;

  snd_reg_ctl #(.ADDR_W(ADDR_W)) u_ctl (
    .busWr      (busWr),
    .busAddr    (busAddr),
    .busWdata   (busWdata),
    .legacyMode (legacyMode),
    .powerOn    (powerOn),
    .strobe     (strobe)
  );

  snd_reg_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .strobe     (strobe),
    .busWdata   (busWdata),
    .busRd      (busRd),
    .busAddr    (busAddr),
    .chanActive (chanActive),
    .busRdata   (busRdata),
    .powerOn    (powerOn),
    .ctrlRegs   (ctrlRegs),
    .lenLoad    (lenLoad),
    .lenValue   (lenValue)
  );

  AST_CLEAR_ON_OFF: assert property (@(posedge clk) disable iff (rst)
    $fell(powerOn) |-> (ctrlRegs == '0)) else $error("bytes not cleared at power-off"); // R2

  AST_OFF_ZERO: assert property (@(posedge clk) disable iff (rst)
    !powerOn |-> ((ctrlRegs & OFF_ZERO) == '0)) else $error("byte nonzero while off"); // R1

  AST_NO_LEN_OFF: assert property (@(posedge clk) disable iff (rst)
    (!powerOn && !legacyMode && busWr) |=> (lenLoad == '0))
    else $error("length strobe while off"); // R4

endmodule

// File: tb/snd_reg_bank_tb.sv
module snd_reg_bank_tb;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         busWr = 1'b0;
  logic         busRd = 1'b0;
  logic [4:0]   busAddr = '0;
  logic [7:0]   busWdata = '0;
  logic         legacyMode = 1'b1;
  logic [3:0]   chanActive = 4'hA;
  logic [7:0]   busRdata;
  logic         powerOn;
  logic [159:0] ctrlRegs;
  logic [3:0]   lenLoad;
  logic [7:0]   lenValue;

  int checkCnt = 0;
  int failCnt  = 0;

  always #2 clk = ~clk;

  snd_reg_bank u_dut (
    .clk(clk), .rst(rst), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .busWdata(busWdata), .legacyMode(legacyMode), .chanActive(chanActive),
    .busRdata(busRdata), .powerOn(powerOn), .ctrlRegs(ctrlRegs),
    .lenLoad(lenLoad), .lenValue(lenValue)
  );

  typedef struct packed {
    logic [4:0] a;
    logic [7:0] w;
    logic [7:0] e;
  } vec_t;

  localparam vec_t VECS [20] = '{
    '{5'd0,  8'h12, 8'h92}, '{5'd1,  8'hC5, 8'hFF}, '{5'd2,  8'hA7, 8'hA7},
    '{5'd3,  8'h3C, 8'hFF}, '{5'd4,  8'h07, 8'hBF}, '{5'd5,  8'h80, 8'hBF},
    '{5'd6,  8'h5A, 8'h5A}, '{5'd7,  8'h01, 8'hFF}, '{5'd8,  8'h40, 8'hFF},
    '{5'd9,  8'h00, 8'h7F}, '{5'd10, 8'h99, 8'hFF}, '{5'd11, 8'h20, 8'hBF},
    '{5'd12, 8'h77, 8'hFF}, '{5'd13, 8'h00, 8'hBF}, '{5'd14, 8'h3F, 8'hFF},
    '{5'd15, 8'hF0, 8'hF0}, '{5'd16, 8'h6D, 8'h6D}, '{5'd17, 8'h40, 8'hFF},
    '{5'd18, 8'h35, 8'h35}, '{5'd19, 8'h9C, 8'h9C}
  };

  task automatic check(string req, logic [159:0] act, logic [159:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] slot(int i);
    return ctrlRegs[i*8 +: 8];
  endfunction

  task automatic doWrite(logic [4:0] a, logic [7:0] d);
    @(negedge clk);
    busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic doRead(logic [4:0] a);
    @(negedge clk);
    busRd = 1'b1; busAddr = a;
    @(negedge clk);
    busRd = 1'b0;
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checkCnt++; failCnt++;
    $display("FAIL watchdog actual=hung expected=done");
    finishRun();
  end

  initial begin
    logic [159:0] snap;
    logic [3:0]   expLd;
    logic [7:0]   expVal;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R7 reset state
    check("R7 power", 160'(powerOn), 160'(1));
    check("R7 rdata", 160'(busRdata), 160'(8'h00));
    check("R7 volume", 160'(slot(18)), 160'(8'h77));
    check("R7 panning", 160'(slot(19)), 160'(8'hF3));
    check("R7 sweep", 160'(slot(0)), 160'(8'h00));
    doRead(5'd20);
    check("R6 master read at reset", 160'(busRdata), 160'(8'hFA));
    doRead(5'd18);
    check("R7 volume read", 160'(busRdata), 160'(8'h77));

    // R10 / R5 / R4 table walk with power on
    for (int k = 0; k < 20; k++) begin
      doWrite(VECS[k].a, VECS[k].w);
      check("R10 stored byte", 160'(slot(int'(VECS[k].a))), 160'(VECS[k].w));
      case (VECS[k].a)
        5'd1:    begin expLd = 4'b0001; expVal = VECS[k].w & 8'h3F; end
        5'd5:    begin expLd = 4'b0010; expVal = VECS[k].w & 8'h3F; end
        5'd10:   begin expLd = 4'b0100; expVal = VECS[k].w; end
        5'd14:   begin expLd = 4'b1000; expVal = VECS[k].w; end
        default: begin expLd = 4'b0000; expVal = 8'h00; end
      endcase
      check("R4 length strobe", 160'(lenLoad), 160'(expLd));
      if (expLd != 4'b0000) check("R4 length value", 160'(lenValue), 160'(expVal));
      doRead(VECS[k].a);
      check("R5 read pattern", 160'(busRdata), 160'(VECS[k].e));
    end

    // R9 hold without strobe
    @(negedge clk);
    busAddr = 5'd2;
    @(negedge clk);
    check("R9 rdata hold", 160'(busRdata), 160'(8'h9C));

    // R8 unmapped
    snap = ctrlRegs;
    doWrite(5'd25, 8'h00);
    check("R8 unmapped write regs", ctrlRegs, snap);
    check("R8 unmapped write power", 160'(powerOn), 160'(1));
    doRead(5'd25);
    check("R8 unmapped read", 160'(busRdata), 160'(8'hFF));
    doRead(5'd31);
    check("R8 unmapped read top", 160'(busRdata), 160'(8'hFF));

    // R2 / R6 power off
    chanActive = 4'h3;
    doWrite(5'd20, 8'h0F);
    check("R6 power bit from data", 160'(powerOn), 160'(0));
    check("R2 cleared at power-off", ctrlRegs, 160'(0));
    doRead(5'd20);
    check("R6 master read off", 160'(busRdata), 160'(8'h73));
    chanActive = 4'h6;
    doRead(5'd20);
    check("R6 master live flags", 160'(busRdata), 160'(8'h76));

    // R1 / R3 / R4 legacy mode while off
    legacyMode = 1'b1;
    doWrite(5'd2, 8'h55);
    check("R1 envelope blocked", 160'(slot(2)), 160'(8'h00));
    doRead(5'd2);
    check("R1 envelope read", 160'(busRdata), 160'(8'h00));
    doWrite(5'd10, 8'hAB);
    check("R3 wave length legacy", 160'(slot(10)), 160'(8'hAB));
    doWrite(5'd1, 8'hFF);
    check("R4 duty stored zero", 160'(slot(1)), 160'(8'h00));
    check("R4 duty strobe legacy", 160'(lenLoad), 160'(4'b0001));
    check("R4 duty value legacy", 160'(lenValue), 160'(8'h3F));
    doWrite(5'd14, 8'h12);
    check("R3 noise length legacy", 160'(slot(14)), 160'(8'h12));

    // non-legacy mode while off
    legacyMode = 1'b0;
    doWrite(5'd10, 8'h44);
    check("R3 wave length blocked", 160'(slot(10)), 160'(8'hAB));
    doWrite(5'd5, 8'hFF);
    check("R4 no strobe off", 160'(lenLoad), 160'(4'b0000));
    doWrite(5'd18, 8'h11);
    check("R1 volume blocked", 160'(slot(18)), 160'(8'h00));

    // power back on and off again
    doWrite(5'd20, 8'h80);
    check("R6 power on", 160'(powerOn), 160'(1));
    check("R3 length kept at power-on", 160'(slot(10)), 160'(8'hAB));
    doWrite(5'd2, 8'h21);
    check("R10 write after power-on", 160'(slot(2)), 160'(8'h21));
    doWrite(5'd20, 8'h00);
    check("R2 second clear", ctrlRegs, 160'(0));

    finishRun();
  end

endmodule